// File: doc/BRIEF.md
# Scaled Fast Clock Follower

This block keeps a local copy of an accelerated layout clock (minutes, hours and a running day count) and moves it forward on its own between periodic synchronisation messages. A free-running real-time tick drives it. Each tick adds the current rate ratio to a sub-minute phase accumulator. Whenever that accumulator holds at least one real minute's worth of ticks (`TICKS_PER_MIN`), the fast clock steps forward one minute and the threshold is taken off, so the remainder carries over. A rate of 0 holds the clock still. A rate of 1 runs it at real time, and a rate of N (up to 127) runs it N times faster.

A bus interface outside this block parses sync messages and presents their fields with a one-cycle strobe. The minute and hour fields arrive as 256 minus the value. Bit 6 of the control byte marks the message as carrying valid time, and a strobe without that bit is dropped. A valid sync replaces the time, the day count and the rate, and clears the phase accumulator. Consumers read the time from the outputs and can use the minute pulse to refresh a display. They never need to poll.

The control FSM has four states. UNSYNCED is the state after reset. FROZEN follows a sync with rate 0. RUNNING accumulates ticks. CATCHUP emits one minute advance per cycle while the accumulator is at or above the threshold. A valid sync moves any state to FROZEN (rate 0) or RUNNING (rate not 0). In RUNNING, a tick that lifts the accumulator to the threshold moves the FSM to CATCHUP. CATCHUP stays put while the reduced accumulator is still at or above the threshold, and otherwise returns to RUNNING.

Top module: `fclk_follower`

## Requirements
- R1: After reset, minutes, hours and days read 0 and the pulse is low. The clock stays at 0 for any number of ticks until a valid sync arrives.
- R2: A strobe with control bit 6 set loads minute = (256 − field) mod 60, hour = (256 − field) mod 24 and the day count as given. The new values are visible the cycle after the strobe. A field of 0 therefore decodes to 16.
- R3: A strobe with control bit 6 clear changes neither the time, the day count nor the rate.
- R4: A valid sync clears the sub-minute phase, so ticks counted before it do not contribute to the next minute.
- R5: Each tick adds the rate to the phase. Once the phase reaches `TICKS_PER_MIN`, the minute advances by one and the threshold is subtracted, keeping the remainder.
- R6: With a rate of 0, ticks never advance the clock.
- R7: When one tick adds several minutes' worth of phase, every one of them is applied, one per cycle, with one pulse each.
- R8: Minute 59 rolls to 0 and advances the hour. Hour 23 rolls to 0 and increments the day count, which wraps modulo 2^DAY_W.
- R9: A valid sync in the same cycle as a pending minute advance wins. The synced time is loaded, and the pending advance is discarded with no pulse.
- R10: `min_pulse_o` is high for exactly one cycle per minute advance, in the same cycle the new minute value first appears. The advance appears one cycle after the tick edge that completes the minute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle real-time tick |
| sync_stb_i | input | 1 | Sync message fields valid this cycle |
| sync_rate_i | input | 7 | Rate ratio, 0 = frozen |
| sync_min_enc_i | input | 8 | 256 minus minutes |
| sync_hr_enc_i | input | 8 | 256 minus hours |
| sync_days_i | input | DAY_W | Day count |
| sync_ctrl_i | input | 8 | Control byte, bit 6 = valid time |
| minute_o | output | 6 | Fast minutes 0–59 |
| hour_o | output | 5 | Fast hours 0–23 |
| days_o | output | DAY_W | Fast day count |
| min_pulse_o | output | 1 | One-cycle pulse per minute advance |

## Verification
The hardest case to reach is a sync that lands while the FSM is in CATCHUP with advances still owed. The window opens only in the few cycles right after a high-rate tick. The bench syncs at rate 127 with a 10-tick threshold, drives one tick, and asserts the sync strobe on the very next cycle. That is the first cycle of CATCHUP. The bench then checks that the synced time stands and that no pulse followed. Multi-minute bursts and day wrap are reached by syncing directly to 23:59 or to the top day count before ticking.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
    localparam int RATE_W        = 7;
    localparam int ENC_W         = 8;
    localparam int CTRL_W        = 8;
    localparam int CTRL_VALID    = 6;
    localparam int MIN_PER_HOUR  = 60;
    localparam int HOUR_PER_DAY  = 24;
    localparam int MIN_W         = 6;
    localparam int HOUR_W        = 5;

    typedef enum logic [1:0] {
        FC_UNSYNCED,
        FC_FROZEN,
        FC_RUNNING,
        FC_CATCHUP
    } fc_state_e;
endpackage

// File: rtl/fclk_decode.sv
// Converts a "256 minus value" field into a value reduced by MODULUS.
module fclk_decode #(
    parameter int MODULUS = 60,
    parameter int OUT_W   = 6
) (
    input  logic [fclk_pkg::ENC_W-1:0] enc_i,
    output logic [OUT_W-1:0]           val_o
);
    localparam int RAW_W = fclk_pkg::ENC_W + 1;

    logic [RAW_W-1:0] raw;

    always_comb begin
        raw   = RAW_W'(256) - {1'b0, enc_i};
        val_o = OUT_W'(raw % RAW_W'(MODULUS));
    end
endmodule

// File: rtl/fclk_phase.sv
// Rate register, sub-minute accumulator and the control FSM.
module fclk_phase
    import fclk_pkg::*;
#(
    parameter int THR   = 60,
    parameter int ACC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sync_ok_i,
    input  logic [RATE_W-1:0] sync_rate_i,
    output logic              adv_o,
    output logic [ACC_W-1:0]  phase_o,
    output logic [RATE_W-1:0] rate_o
);
    localparam logic [ACC_W-1:0] THR_V = ACC_W'(THR);

    fc_state_e          state_q, state_d;
    logic [ACC_W-1:0]   acc_q, acc_d;
    logic [RATE_W-1:0]  rate_q, rate_d;
    logic [ACC_W-1:0]   tick_add;

    // next-state and datapath
    always_comb begin
        state_d  = state_q;
        acc_d    = acc_q;
        rate_d   = rate_q;
        tick_add = tick_i ? ACC_W'(rate_q) : '0;
        if (sync_ok_i) begin
            rate_d  = sync_rate_i;
            acc_d   = '0;
            state_d = (sync_rate_i == '0) ? FC_FROZEN : FC_RUNNING;
        end else begin
            unique case (state_q)
                FC_UNSYNCED, FC_FROZEN: begin
                    acc_d = acc_q;
                end
                FC_RUNNING: begin
                    acc_d   = acc_q + tick_add;
                    state_d = (acc_d >= THR_V) ? FC_CATCHUP : FC_RUNNING;
                end
                FC_CATCHUP: begin
                    acc_d   = acc_q - THR_V + tick_add;
                    state_d = (acc_d >= THR_V) ? FC_CATCHUP : FC_RUNNING;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FC_UNSYNCED;
            acc_q   <= '0;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            rate_q  <= rate_d;
        end
    end

    // outputs
    always_comb begin
        adv_o   = (state_q == FC_CATCHUP) && !sync_ok_i;
        phase_o = acc_q;
        rate_o  = rate_q;
    end
endmodule

// File: rtl/fclk_tod.sv
// Minute / hour / day counters with load and carry chain.
module fclk_tod
    import fclk_pkg::*;
#(
    parameter int DAY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MIN_W-1:0]  load_min_i,
    input  logic [HOUR_W-1:0] load_hour_i,
    input  logic [DAY_W-1:0]  load_day_i,
    input  logic              adv_i,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [DAY_W-1:0]  day_o,
    output logic              pulse_o
);
    localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(MIN_PER_HOUR - 1);
    localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(HOUR_PER_DAY - 1);

    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic              pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q   <= '0;
            hour_q  <= '0;
            day_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= adv_i && !load_i;
            if (load_i) begin
                min_q  <= load_min_i;
                hour_q <= load_hour_i;
                day_q  <= load_day_i;
            end else if (adv_i) begin
                if (min_q == MIN_TOP) begin
                    min_q <= '0;
                    if (hour_q == HOUR_TOP) begin
                        hour_q <= '0;
                        day_q  <= day_q + 1'b1;
                    end else begin
                        hour_q <= hour_q + 1'b1;
                    end
                end else begin
                    min_q <= min_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        min_o   = min_q;
        hour_o  = hour_q;
        day_o   = day_q;
        pulse_o = pulse_q;
    end
endmodule

// File: rtl/fclk_follower.sv
module fclk_follower
    import fclk_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60,
    parameter int DAY_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sync_stb_i,
    input  logic [6:0]        sync_rate_i,
    input  logic [7:0]        sync_min_enc_i,
    input  logic [7:0]        sync_hr_enc_i,
    input  logic [DAY_W-1:0]  sync_days_i,
    input  logic [7:0]        sync_ctrl_i,
    output logic [5:0]        minute_o,
    output logic [4:0]        hour_o,
    output logic [DAY_W-1:0]  days_o,
    output logic              min_pulse_o
);
    localparam int ACC_W = $clog2(TICKS_PER_MIN + 2 * (1 << RATE_W));

    logic              sync_ok;
    logic              adv;
    logic [ACC_W-1:0]  phase_w;
    logic [RATE_W-1:0] rate_w;
    logic [MIN_W-1:0]  dec_min;
    logic [HOUR_W-1:0] dec_hour;
    logic              unused_ctrl;

    assign sync_ok     = sync_stb_i && sync_ctrl_i[CTRL_VALID];
    assign unused_ctrl = ^{sync_ctrl_i[7], sync_ctrl_i[5:0]};

    fclk_decode #(.MODULUS(MIN_PER_HOUR), .OUT_W(MIN_W)) u_dec_min (
        .enc_i (sync_min_enc_i),
        .val_o (dec_min)
    );

    fclk_decode #(.MODULUS(HOUR_PER_DAY), .OUT_W(HOUR_W)) u_dec_hour (
        .enc_i (sync_hr_enc_i),
        .val_o (dec_hour)
    );

    fclk_phase #(.THR(TICKS_PER_MIN), .ACC_W(ACC_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .sync_ok_i   (sync_ok),
        .sync_rate_i (sync_rate_i),
        .adv_o       (adv),
        .phase_o     (phase_w),
        .rate_o      (rate_w)
    );

    fclk_tod #(.DAY_W(DAY_W)) u_tod (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sync_ok),
        .load_min_i  (dec_min),
        .load_hour_i (dec_hour),
        .load_day_i  (sync_days_i),
        .adv_i       (adv),
        .min_o       (minute_o),
        .hour_o      (hour_o),
        .day_o       (days_o),
        .pulse_o     (min_pulse_o)
    );
endmodule

// File: rtl/fclk_follower_chk.sv
module fclk_follower_chk #(
    parameter int THR   = 60,
    parameter int ACC_W = 9,
    parameter int DAY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_ok,
    input logic             sync_bad,
    input logic [5:0]       minute_o,
    input logic [4:0]       hour_o,
    input logic [DAY_W-1:0] days_o,
    input logic             min_pulse_o,
    input logic [6:0]       rate_w,
    input logic [ACC_W-1:0] phase_w
);
    p_invalid_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_bad |=> (rate_w == $past(rate_w)) &&
                     ((minute_o == $past(minute_o)) || min_pulse_o));

    p_phase_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> (phase_w == '0));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_w < ACC_W'(THR + 128));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_w == '0) |=> !min_pulse_o);

    p_ranges_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_o < 6'd60) && (hour_o < 5'd24));

    p_day_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (min_pulse_o && minute_o == '0 && hour_o == '0) |->
            days_o == DAY_W'($past(days_o) + 1'b1));

    p_sync_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> !min_pulse_o);

    p_pulse_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        min_pulse_o |-> (minute_o != $past(minute_o)));

    p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!min_pulse_o && !$past(sync_ok)) |-> $stable(minute_o));
endmodule

bind fclk_follower fclk_follower_chk #(
    .THR   (TICKS_PER_MIN),
    .ACC_W (ACC_W),
    .DAY_W (DAY_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_ok     (sync_ok),
    .sync_bad    (sync_stb_i && !sync_ctrl_i[6]),
    .minute_o    (minute_o),
    .hour_o      (hour_o),
    .days_o      (days_o),
    .min_pulse_o (min_pulse_o),
    .rate_w      (rate_w),
    .phase_w     (phase_w)
);

// File: tb/fclk_follower_tb_top.sv
module fclk_follower_tb_top;
    localparam int THR   = 10;
    localparam int DAY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             sync_stb_i = 1'b0;
    logic [6:0]       sync_rate_i = '0;
    logic [7:0]       sync_min_enc_i = '0;
    logic [7:0]       sync_hr_enc_i = '0;
    logic [DAY_W-1:0] sync_days_i = '0;
    logic [7:0]       sync_ctrl_i = '0;
    logic [5:0]       minute_o;
    logic [4:0]       hour_o;
    logic [DAY_W-1:0] days_o;
    logic             min_pulse_o;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fclk_follower #(.TICKS_PER_MIN(THR), .DAY_W(DAY_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .sync_stb_i     (sync_stb_i),
        .sync_rate_i    (sync_rate_i),
        .sync_min_enc_i (sync_min_enc_i),
        .sync_hr_enc_i  (sync_hr_enc_i),
        .sync_days_i    (sync_days_i),
        .sync_ctrl_i    (sync_ctrl_i),
        .minute_o       (minute_o),
        .hour_o         (hour_o),
        .days_o         (days_o),
        .min_pulse_o    (min_pulse_o)
    );

    always @(negedge clk) if (rst_n && min_pulse_o) pulse_cnt++;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int v);
        return (v == 0) ? 8'd16 : 8'(256 - v);
    endfunction

    task automatic send_sync(input int rate, input int mn, input int hr, input int dy, input logic [7:0] ctrl);
        sync_stb_i     = 1'b1;
        sync_rate_i    = 7'(rate);
        sync_min_enc_i = enc(mn);
        sync_hr_enc_i  = enc(hr);
        sync_days_i    = DAY_W'(dy);
        sync_ctrl_i    = ctrl;
        @(negedge clk);
        sync_stb_i     = 1'b0;
    endtask

    task automatic tick_once();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic check_time(input string req, input int mn, input int hr, input int dy);
        check_eq(req, "minute", int'(minute_o), mn);
        check_eq(req, "hour", int'(hour_o), hr);
        check_eq(req, "days", int'(days_o), dy);
    endtask

    task automatic t_reset();
        check_time("R1", 0, 0, 0);
        check_eq("R1", "pulse", int'(min_pulse_o), 0);
        for (int i = 0; i < 5; i++) tick_once();
        check_time("R1", 0, 0, 0);
    endtask

    task automatic t_sync_load();
        send_sync(1, 37, 14, 5, 8'h40);
        check_time("R2", 37, 14, 5);
        sync_stb_i = 1'b1; sync_rate_i = 7'd0; sync_min_enc_i = 8'd0;
        sync_hr_enc_i = 8'd0; sync_days_i = '0; sync_ctrl_i = 8'hC0;
        @(negedge clk);
        sync_stb_i = 1'b0;
        check_time("R2", 16, 16, 0);
    endtask

    task automatic t_invalid();
        send_sync(1, 2, 2, 9, 8'h40);
        send_sync(127, 45, 9, 99, 8'h3F);
        check_time("R3", 2, 2, 9);
        for (int i = 0; i < 9; i++) tick_once();
        check_eq("R3", "minute after 9 ticks", int'(minute_o), 2);
        tick_once();
        check_eq("R3", "minute after 10 ticks", int'(minute_o), 3);
    endtask

    task automatic t_remainder();
        send_sync(3, 0, 10, 0, 8'h40);
        for (int i = 0; i < 3; i++) tick_once();
        check_eq("R5", "minute after 3 ticks", int'(minute_o), 0);
        tick_once();
        check_eq("R5", "minute after 4 ticks", int'(minute_o), 1);
        tick_once(); tick_once();
        check_eq("R5", "minute after 6 ticks", int'(minute_o), 1);
        tick_once();
        check_eq("R5", "minute after 7 ticks", int'(minute_o), 2);
    endtask

    task automatic t_phase_reset();
        send_sync(3, 0, 1, 0, 8'h40);
        for (int i = 0; i < 3; i++) tick_once();
        send_sync(3, 0, 1, 0, 8'h40);
        for (int i = 0; i < 3; i++) tick_once();
        check_eq("R4", "minute after resync + 3 ticks", int'(minute_o), 0);
        tick_once();
        check_eq("R4", "minute after resync + 4 ticks", int'(minute_o), 1);
    endtask

    task automatic t_freeze();
        int p0;
        send_sync(0, 15, 7, 2, 8'h40);
        p0 = pulse_cnt;
        for (int i = 0; i < 30; i++) tick_once();
        check_time("R6", 15, 7, 2);
        check_eq("R6", "pulses", pulse_cnt - p0, 0);
    endtask

    task automatic t_burst();
        int p0;
        send_sync(127, 0, 0, 0, 8'h40);
        p0 = pulse_cnt;
        tick_once();
        check_eq("R7", "minute after burst", int'(minute_o), 12);
        check_eq("R7", "pulses after burst", pulse_cnt - p0, 12);
        tick_once();
        check_eq("R7", "minute after 2nd burst", int'(minute_o), 25);
        check_eq("R7", "pulses after 2nd burst", pulse_cnt - p0, 25);
    endtask

    task automatic t_roll();
        send_sync(10, 59, 10, 1, 8'h40);
        tick_once();
        check_time("R8", 0, 11, 1);
        send_sync(10, 59, 23, 3, 8'h40);
        tick_once();
        check_time("R8", 0, 0, 4);
        send_sync(10, 59, 23, 255, 8'h40);
        tick_once();
        check_time("R8", 0, 0, 0);
    endtask

    task automatic t_priority();
        int p0;
        send_sync(127, 0, 0, 0, 8'h40);
        p0 = pulse_cnt;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        send_sync(1, 30, 5, 6, 8'h40);
        repeat (16) @(negedge clk);
        check_time("R9", 30, 5, 6);
        check_eq("R9", "pulses", pulse_cnt - p0, 0);
    endtask

    task automatic t_pulse_timing();
        send_sync(10, 20, 3, 0, 8'h40);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check_eq("R10", "pulse at tick edge", int'(min_pulse_o), 0);
        check_eq("R10", "minute at tick edge", int'(minute_o), 20);
        @(negedge clk);
        check_eq("R10", "pulse next cycle", int'(min_pulse_o), 1);
        check_eq("R10", "minute next cycle", int'(minute_o), 21);
        @(negedge clk);
        check_eq("R10", "pulse after", int'(min_pulse_o), 0);
        check_eq("R10", "minute after", int'(minute_o), 21);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_load();
        t_invalid();
        t_remainder();
        t_phase_reset();
        t_freeze();
        t_burst();
        t_roll();
        t_priority();
        t_pulse_timing();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule